// File: doc/BRIEF.md
# Peripheral DMA Channel with Block Limit

This block is one DMA channel between a print-path data source and memory. Software sets a control word, a start address and a 10-bit block size, then sets the enable bit. Each request from the peripheral goes through a two-stage synchronizer and starts a one-clock DMA cycle. During that cycle the block drives an address and either a read or a write strobe. After each cycle the address steps by the selected amount and the block counter counts down.

The size counter counts transfers, in halfwords. A size of zero means the channel runs without limit. With a non-zero size, the channel disables itself after the last transfer and raises a level interrupt. The interrupt stays high until software writes the size register again. When the data comes through the bit-rotation path, a request waits while the rotation output register is not ready. When external memory is written directly, the block turns off its own bus drivers for the cycle.

Top module: `pdma_block_channel`

## Requirements
- R1: After reset the size register reads 0000h (enable 0, count 0), the address and control registers read 0, the interrupt is low, both strobes are low and the bus driver enable is high.
- R2: A request that is high in clock k starts a DMA cycle in clock k+3. A strobe lasts exactly one clock, and at least one idle clock follows every DMA cycle, even while the request stays high.
- R3: Register index 1 holds the size in bits [9:0] and the enable in bit 15, and reads back as {enable, 5'b0, count}. A write loads the count only while enable is 0. Bit 15 of every write to index 1 becomes the new enable.
- R4: With a non-zero size, every DMA cycle lowers the count by one. After the cycle that brings the count to zero, the enable reads 0, the count reads 0, the interrupt is high, and no further requests are served.
- R5: A size of 0 selects unlimited mode. Requests are served without end, the count stays 0, the enable stays 1 and no interrupt is raised.
- R6: Any write to register index 1 clears the interrupt.
- R7: Control bits [1:0] choose the address step taken after each cycle: 0 hold, 1 +1, 2 +2, 3 -2. The address register is driven on dmaAddr during the cycle.
- R8: The address register, at index 2, can be written only while enable is 0. Writes while enabled leave it unchanged.
- R9: Control bit 2 selects the direction: 1 asserts dmaWrStb for the cycle, 0 asserts dmaRdStb.
- R10: Control bit 3 selects external memory (1) or the rotation path (0). busDrvEn is low only during a write cycle on the external-memory path and is high at all other times.
- R11: On the rotation path, no DMA cycle starts while rotReady is low. A request held high is served once rotReady rises.
- R12: On the rotation path with control bit 4 = 0 (byte width), any non-hold step mode steps the address by +1. Bit 4 = 1 selects halfword width, and the step modes then apply as listed in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index: 0 control, 1 size/enable, 2 address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| dmaReqRaw | input | 1 | Unsynchronized request from the peripheral |
| rotReady | input | 1 | Rotation output register holds valid data |
| dmaAddr | output | 16 | Address for the current DMA cycle |
| dmaRdStb | output | 1 | Read strobe during a DMA cycle |
| dmaWrStb | output | 1 | Write strobe during a DMA cycle |
| busDrvEn | output | 1 | Bus output driver enable |
| dmaIrq | output | 1 | Block-complete interrupt (level) |

## Verification
The assertions assume that the control register stays the same while a block is running, and that the peripheral holds its request until it is served whenever rotReady may be low. The bench writes the control word only while the channel is disabled. It holds requests as levels in the hold-off and back-to-back tests, and sends single-clock pulses spaced five clocks apart everywhere else. Random trials draw the step mode, path, width, direction, start address and a size from 1 to 12. Each trial sends two requests more than the size, so the requests that arrive after the channel disables itself are also checked.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC1 = 2'd1,
    STEP_INC2 = 2'd2,
    STEP_DEC2 = 2'd3
  } stepMode_e;

  // control word: bit4 halfWide, bit3 extMem, bit2 dirWrite, bits1:0 step
  typedef struct packed {
    logic      halfWide;
    logic      extMem;
    logic      dirWrite;
    stepMode_e step;
  } ctrlCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCtrl;
    logic loadAddr;
    logic loadSize;
    logic cycleEnd;
  } ctrlStrobe_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SIZE = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;

endpackage

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic        wrEnableBit,
  input  logic        dmaReqRaw,
  input  logic        rotReady,
  input  logic        cfgExtMem,
  input  logic        cfgDirWrite,
  input  logic        lastXfer,
  output ctrlStrobe_t strb,
  output logic        enable,
  output logic        dmaRdStb,
  output logic        dmaWrStb,
  output logic        busDrvEn,
  output logic        dmaIrq
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic reqSync;
  logic cycleAct;
  logic startCycle;
  logic sizeWr;
  logic blockDone;

  // request synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], dmaReqRaw};
  end
  assign reqSync = syncQ[SYNC_STAGES-1];

  assign sizeWr     = regWrEn && (regAddr == REG_SIZE);
  assign blockDone  = cycleAct && lastXfer;
  assign startCycle = enable && reqSync && (cfgExtMem || rotReady) && !cycleAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycleAct <= 1'b0;
    else       cycleAct <= startCycle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enable <= 1'b0;
    else if (blockDone) enable <= 1'b0;
    else if (sizeWr)    enable <= wrEnableBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dmaIrq <= 1'b0;
    else if (blockDone) dmaIrq <= 1'b1;
    else if (sizeWr)    dmaIrq <= 1'b0;
  end

  always_comb begin
    strb.cycleEnd = cycleAct;
    strb.loadSize = sizeWr && !enable;
    strb.loadAddr = regWrEn && (regAddr == REG_ADDR) && !enable;
    strb.loadCtrl = regWrEn && (regAddr == REG_CTRL);
  end

  assign dmaRdStb = cycleAct && !cfgDirWrite;
  assign dmaWrStb = cycleAct && cfgDirWrite;
  assign busDrvEn = !(cycleAct && cfgExtMem && cfgDirWrite);

  generate
    if (SYNC_STAGES == 2) begin : g_syncChk
      assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
        cycleAct |-> $past(dmaReqRaw, 3));
    end
  endgenerate

  assert_cycle_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    cycleAct |=> !cycleAct);

  assert_block_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> (!enable && dmaIrq));

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaIrq) |-> ($past(lastXfer) && $past(cycleAct)));

  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sizeWr && !blockDone) |=> !dmaIrq);

  assert_rot_holdoff_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cycleAct && !cfgExtMem) |-> $past(rotReady));

endmodule

// File: rtl/pdma_datapath.sv
module pdma_datapath
  import pdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strb,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWrData,
  input  logic          enable,
  output ctrlCfg_t      cfg,
  output logic [AW-1:0] dmaAddr,
  output logic          lastXfer,
  output logic [DW-1:0] regRdData
);

  localparam int CFGW = $bits(ctrlCfg_t);
  localparam logic [AW-1:0] STEP_ONE  = AW'(1);
  localparam logic [AW-1:0] STEP_TWO  = AW'(2);
  localparam logic [AW-1:0] STEP_NEG2 = {{(AW-1){1'b1}}, 1'b0};

  ctrlCfg_t      cfgQ;
  logic [CW-1:0] countQ;
  logic          limitedQ;
  logic [AW-1:0] addrQ;
  stepMode_e     effStep;
  logic [AW-1:0] stepVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cfgQ <= '0;
    else if (strb.loadCtrl) cfgQ <= ctrlCfg_t'(regWrData[CFGW-1:0]);
  end
  assign cfg = cfgQ;

  // block counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ   <= '0;
      limitedQ <= 1'b0;
    end else if (strb.loadSize) begin
      countQ   <= regWrData[CW-1:0];
      limitedQ <= |regWrData[CW-1:0];
    end else if (strb.cycleEnd && limitedQ && (countQ != '0)) begin
      countQ <= countQ - 1'b1;
    end
  end
  assign lastXfer = limitedQ && (countQ == CW'(1));

  // byte-wide rotation path forces a unit step
  always_comb begin
    effStep = cfgQ.step;
    if (!cfgQ.extMem && !cfgQ.halfWide && (cfgQ.step != STEP_HOLD))
      effStep = STEP_INC1;
  end

  always_comb begin
    case (effStep)
      STEP_INC1: stepVal = STEP_ONE;
      STEP_INC2: stepVal = STEP_TWO;
      STEP_DEC2: stepVal = STEP_NEG2;
      default:   stepVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrQ <= '0;
    else if (strb.loadAddr) addrQ <= regWrData[AW-1:0];
    else if (strb.cycleEnd) addrQ <= addrQ + stepVal;
  end
  assign dmaAddr = addrQ;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: regRdData[CFGW-1:0] = cfgQ;
      REG_SIZE: begin
        regRdData[CW-1:0] = countQ;
        regRdData[DW-1]   = enable;
      end
      REG_ADDR: regRdData[AW-1:0] = addrQ;
      default:  regRdData = '0;
    endcase
  end

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadSize && !strb.cycleEnd) |=> $stable(countQ));

  assert_unlimited_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !limitedQ |-> (countQ == '0));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadAddr && !strb.cycleEnd) |=> $stable(addrQ));

  assert_byte_step_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cycleEnd && !strb.loadAddr && !cfgQ.extMem && !cfgQ.halfWide
     && (cfgQ.step != STEP_HOLD) && !strb.loadCtrl) |=> (addrQ == $past(addrQ) + STEP_ONE));

endmodule

// File: rtl/pdma_block_channel.sv
module pdma_block_channel
  import pdma_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CW          = 10,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic          dmaReqRaw,
  input  logic          rotReady,
  output logic [AW-1:0] dmaAddr,
  output logic          dmaRdStb,
  output logic          dmaWrStb,
  output logic          busDrvEn,
  output logic          dmaIrq
);

  ctrlStrobe_t strb;
  ctrlCfg_t    cfg;
  logic        enable;
  logic        lastXfer;

  pdma_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .wrEnableBit(regWrData[DW-1]),
    .dmaReqRaw  (dmaReqRaw),
    .rotReady   (rotReady),
    .cfgExtMem  (cfg.extMem),
    .cfgDirWrite(cfg.dirWrite),
    .lastXfer   (lastXfer),
    .strb       (strb),
    .enable     (enable),
    .dmaRdStb   (dmaRdStb),
    .dmaWrStb   (dmaWrStb),
    .busDrvEn   (busDrvEn),
    .dmaIrq     (dmaIrq)
  );

  pdma_datapath #(
    .AW(AW),
    .CW(CW),
    .DW(DW)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .enable   (enable),
    .cfg      (cfg),
    .dmaAddr  (dmaAddr),
    .lastXfer (lastXfer),
    .regRdData(regRdData)
  );

endmodule

// File: tb/test_pdma_block_channel.sv
`timescale 1ns/1ps
module test_pdma_block_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        dmaReqRaw = 1'b0;
  logic        rotReady = 1'b1;
  logic [15:0] dmaAddr;
  logic        dmaRdStb, dmaWrStb, busDrvEn, dmaIrq;

  int nChecks = 0;
  int nFail = 0;
  int cycleCnt = 0;
  bit prevStb = 1'b0;
  logic [15:0] expAddr = 16'h0;
  int  curMode = 0;
  bit  curExt = 1'b0, curDir = 1'b0, curHalf = 1'b0;

  always #4 clk = ~clk;

  pdma_block_channel i_pdma_block_channel (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dmaReqRaw(dmaReqRaw),
    .rotReady(rotReady), .dmaAddr(dmaAddr), .dmaRdStb(dmaRdStb),
    .dmaWrStb(dmaWrStb), .busDrvEn(busDrvEn), .dmaIrq(dmaIrq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nextAddr(input logic [15:0] a, input int mode,
                                           input bit ext, input bit half);
    int m = mode;
    if (!ext && !half && m != 0) m = 1;
    case (m)
      1: return a + 16'd1;
      2: return a + 16'd2;
      3: return a - 16'd2;
      default: return a;
    endcase
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic reqPulse();
    @(negedge clk); dmaReqRaw = 1'b1;
    @(negedge clk); dmaReqRaw = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int mode, input bit ext, input bit dir, input bit half,
                       input logic [15:0] a);
    curMode = mode; curExt = ext; curDir = dir; curHalf = half;
    writeReg(2'd0, {11'd0, half, ext, dir, mode[1:0]});
    writeReg(2'd2, a);
    expAddr = a;
    cycleCnt = 0;
  endtask

  // cycle monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (dmaRdStb || dmaWrStb) begin
        check(dmaAddr == expAddr, "R7 cycle address", dmaAddr, expAddr);
        check(dmaWrStb == curDir && dmaRdStb == !curDir, "R9 strobe select",
              {dmaWrStb, dmaRdStb}, {curDir, !curDir});
        check(busDrvEn == !(curExt && curDir), "R10 driver enable in cycle",
              busDrvEn, !(curExt && curDir));
        check(!prevStb, "R2 idle clock between cycles", prevStb, 0);
        expAddr = nextAddr(expAddr, curMode, curExt, curHalf);
        cycleCnt++;
        prevStb = 1'b1;
      end else begin
        if (!busDrvEn) check(1'b0, "R10 driver enable outside cycle", busDrvEn, 1);
        prevStb = 1'b0;
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    finishRun();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(2'd1, d); check(d == 16'h0000, "R1 size reset", d, 0);
    readReg(2'd2, d); check(d == 16'h0000, "R1 addr reset", d, 0);
    readReg(2'd0, d); check(d == 16'h0000, "R1 ctrl reset", d, 0);
    check(!dmaIrq && !dmaRdStb && !dmaWrStb && busDrvEn, "R1 outputs reset",
          {dmaIrq, dmaRdStb, dmaWrStb, busDrvEn}, 4'b0001);

    // R2 latency, R4 completion, R7 +2 step
    setup(2, 1'b1, 1'b0, 1'b0, 16'h0100);
    writeReg(2'd1, 16'h8003);
    @(negedge clk); dmaReqRaw = 1'b1;
    @(negedge clk); dmaReqRaw = 1'b0;
    check(!dmaRdStb, "R2 no strobe after 1 clock", dmaRdStb, 0);
    @(negedge clk);
    check(!dmaRdStb, "R2 no strobe after 2 clocks", dmaRdStb, 0);
    @(negedge clk);
    check(dmaRdStb, "R2 strobe after 3 clocks", dmaRdStb, 1);
    @(negedge clk);
    check(!dmaRdStb, "R2 strobe one clock", dmaRdStb, 0);
    repeat (4) reqPulse();
    check(cycleCnt == 3, "R4 cycle count", cycleCnt, 3);
    readReg(2'd1, d); check(d == 16'h0000, "R4 enable and count cleared", d, 0);
    check(dmaIrq, "R4 irq raised", dmaIrq, 1);
    readReg(2'd2, d); check(d == 16'h0106, "R7 final address +2", d, 16'h0106);
    writeReg(2'd1, 16'h0000);
    check(!dmaIrq, "R6 irq cleared by size write", dmaIrq, 0);

    // R3 / R8 writes ignored while enabled; -2 step; external write
    setup(3, 1'b1, 1'b1, 1'b0, 16'h0200);
    writeReg(2'd1, 16'h8004);
    writeReg(2'd1, 16'h8009);
    readReg(2'd1, d); check(d == 16'h8004, "R3 size write ignored", d, 16'h8004);
    writeReg(2'd2, 16'h5555);
    readReg(2'd2, d); check(d == 16'h0200, "R8 addr write ignored", d, 16'h0200);
    repeat (5) reqPulse();
    check(cycleCnt == 4, "R4 cycle count dec", cycleCnt, 4);
    readReg(2'd2, d); check(d == 16'h01F8, "R7 final address -2", d, 16'h01F8);
    check(dmaIrq, "R4 irq raised", dmaIrq, 1);
    writeReg(2'd1, 16'h0000);

    // R5 unlimited
    setup(1, 1'b1, 1'b0, 1'b0, 16'h0000);
    writeReg(2'd1, 16'h8000);
    repeat (20) reqPulse();
    check(cycleCnt == 20, "R5 all requests served", cycleCnt, 20);
    readReg(2'd1, d); check(d == 16'h8000, "R5 enable kept count zero", d, 16'h8000);
    check(!dmaIrq, "R5 no irq", dmaIrq, 0);
    readReg(2'd2, d); check(d == 16'h0014, "R7 final address +1", d, 16'h0014);
    // R2 held request alternates
    cycleCnt = 0;
    @(negedge clk); dmaReqRaw = 1'b1;
    repeat (20) @(negedge clk);
    dmaReqRaw = 1'b0;
    repeat (5) @(negedge clk);
    check(cycleCnt >= 9 && cycleCnt <= 11, "R2 held request rate", cycleCnt, 10);
    writeReg(2'd1, 16'h0000);

    // R11 rotation hold-off
    rotReady = 1'b0;
    setup(2, 1'b0, 1'b0, 1'b1, 16'h0040);
    writeReg(2'd1, 16'h8002);
    @(negedge clk); dmaReqRaw = 1'b1;
    repeat (12) @(negedge clk);
    check(cycleCnt == 0, "R11 held off while not ready", cycleCnt, 0);
    rotReady = 1'b1;
    repeat (10) @(negedge clk);
    dmaReqRaw = 1'b0;
    repeat (4) @(negedge clk);
    check(cycleCnt == 2, "R11 served after ready", cycleCnt, 2);
    check(dmaIrq, "R4 irq after held block", dmaIrq, 1);
    readReg(2'd2, d); check(d == 16'h0044, "R11 halfword address", d, 16'h0044);
    writeReg(2'd1, 16'h0000);

    // R12 byte-wide rotation forces +1
    setup(3, 1'b0, 1'b0, 1'b0, 16'h0080);
    writeReg(2'd1, 16'h8003);
    repeat (3) reqPulse();
    readReg(2'd2, d); check(d == 16'h0083, "R12 byte step", d, 16'h0083);
    check(cycleCnt == 3, "R12 cycle count", cycleCnt, 3);
    writeReg(2'd1, 16'h0000);

    // constrained random trials
    for (int t = 0; t < 10; t++) begin
      int mode = int'($urandom_range(3, 0));
      bit ext  = 1'($urandom_range(1, 0));
      bit dir  = 1'($urandom_range(1, 0));
      bit half = 1'($urandom_range(1, 0));
      int sz   = int'($urandom_range(12, 1));
      logic [15:0] a = 16'($urandom);
      setup(mode, ext, dir, half, a);
      writeReg(2'd1, 16'h8000 | 16'(sz));
      check(!dmaIrq, "R6 irq clear at start", dmaIrq, 0);
      for (int p = 0; p < sz + 2; p++) reqPulse();
      check(cycleCnt == sz, "R4 random cycle count", cycleCnt, sz);
      readReg(2'd1, d); check(d == 16'h0000, "R4 random completion", d, 0);
      check(dmaIrq, "R4 random irq", dmaIrq, 1);
      readReg(2'd2, d); check(d == expAddr, "R7 random final address", d, expAddr);
      writeReg(2'd1, 16'h0000);
    end

    finishRun();
  end

endmodule